// File: doc/BRIEF.md
# Two-Colour Sprite Display Engine

This block composes a raster image from one-bit-per-pixel sprites and sends it to a flat panel as 18-bit RGB666 pixels, together with data-enable, horizontal and vertical sync. A host programs a background colour, sixteen two-colour palettes, per-sprite descriptors and bitmap rows through a write-only 32-bit port. Every active pixel is resolved in one pass. Each enabled sprite checks whether the current raster position lies inside its box and reads its bitmap bit. The visible sprite on the lowest-numbered plane wins, and on a tie the lowest sprite index wins. Where no sprite shows, the background colour appears.

The raster is 720 by 480 active pixels by default, with blanking intervals that can be set by parameters. After the last active pixel of each frame, the engine raises a one-cycle interrupt pulse so that the host can update sprites during vertical blanking. Up to 128 sprites share a bitmap store. Each sprite is at most 32 by 32 pixels and uses one 32-bit word per row.

Top module: `sprite_engine`

## Requirements
- R1: While rst_n is low, pix_data is 0 and pix_de, hsync, vsync and frame_irq are low. Descriptors come out of reset disabled.
- R2: A frame is V_TOTAL lines, and each line is H_TOTAL cycles. pix_de is high for H_ACTIVE×V_ACTIVE cycles per frame, and pix_data is 0 whenever pix_de is low.
- R3: hsync is high for H_SYNC cycles per line, starting H_FRONT+1 cycles after the line's last active pixel. vsync is high for V_SYNC whole lines per frame. Neither is ever high while pix_de is high.
- R4: frame_irq is a one-cycle pulse, once per frame, in the same cycle as the frame's last active pixel (column H_ACTIVE-1, line V_ACTIVE-1).
- R5: wr_addr splits into a 2-bit region (top bits) and an index. Region 0, index 0 is the background colour (data[17:0]). Region 1, index 2·p+e is entry e of palette p (data[17:0]). Region 2, index 2·s+w is word w of sprite s. Region 3, index n is bitmap word n.
- R6: Descriptor word 0 holds x in [10:0] and y in [26:16]. Word 1 holds width-1 in [4:0], height-1 in [9:5], plane in [11:10], palette in [15:12], enable in [16], opaque in [17] and bitmap offset in [31:20].
- R7: Screen row y+r of a sprite reads bitmap word offset+r. Bit c of that word is screen column x+c. A set bit shows palette entry 1.
- R8: A clear bitmap bit is transparent, so lower-priority sprites or the background show through. When the sprite's opaque flag is set, a clear bit shows palette entry 0 instead.
- R9: Active pixels that no sprite covers visibly show the background colour.
- R10: Where visible sprites overlap on different planes, the lower-numbered plane wins, whatever the sprite index.
- R11: Where visible sprites overlap on the same plane, the lower sprite index wins.
- R12: A sprite whose enable bit is clear has no effect on any pixel, even with its opaque flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | IDX_W+2 | Host word address: region in the top two bits, index below |
| wr_data | input | 32 | Host write data |
| pix_data | output | 18 | RGB666 pixel |
| pix_de | output | 1 | Active-pixel enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| frame_irq | output | 1 | End-of-frame interrupt pulse |

## Verification
A wrong raster counter shows within one frame: the interrupt spacing, the count of enabled pixels or the sync positions differ from H_TOTAL·V_TOTAL arithmetic. A wrong descriptor field, bitmap address or priority choice changes the colour of specific pixels in the first full frame captured after the host writes. The bench therefore compares every active pixel of that frame against a hand-built image. The overlap scenarios are placed so that each wrong winner, such as a higher plane, a higher index, a transparent pixel taken as opaque or a disabled sprite, produces a colour that no correct design would show there.

// File: rtl/spr_pkg.sv
package spr_pkg;
   localparam int COLOR_W    = 18;
   localparam int NUM_PLANES = 4;
   localparam int NUM_PAL    = 16;
   localparam int ROW_BITS   = 32;

   localparam logic [1:0] RGN_BG   = 2'd0;
   localparam logic [1:0] RGN_PAL  = 2'd1;
   localparam logic [1:0] RGN_DESC = 2'd2;
   localparam logic [1:0] RGN_BITS = 2'd3;

   typedef struct packed {
      logic [10:0] x;
      logic [10:0] y;
      logic [4:0]  wm1;
      logic [4:0]  hm1;
      logic [1:0]  plane;
      logic [3:0]  pal;
      logic        en;
      logic        opaque;
      logic [11:0] off;
   } desc_t;

   function automatic int idx_width(int n_spr, int n_words);
      int w;
      w = 5;
      if ($clog2(n_words) > w)   w = $clog2(n_words);
      if ($clog2(2 * n_spr) > w) w = $clog2(2 * n_spr);
      return w;
   endfunction
endpackage

// File: rtl/spr_raster.sv
module spr_raster #(
   parameter int H_ACTIVE = 720,
   parameter int H_FRONT  = 16,
   parameter int H_SYNC   = 62,
   parameter int H_BACK   = 60,
   parameter int V_ACTIVE = 480,
   parameter int V_FRONT  = 9,
   parameter int V_SYNC   = 6,
   parameter int V_BACK   = 30,
   parameter int X_W      = 10,
   parameter int Y_W      = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [X_W-1:0] h,
   output logic [Y_W-1:0] v,
   output logic           active,
   output logic           hs,
   output logic           vs,
   output logic           last
);
   localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
   localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
   localparam int HS_ON   = H_ACTIVE + H_FRONT;
   localparam int VS_ON   = V_ACTIVE + V_FRONT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h <= '0;
         v <= '0;
      end else if (32'(h) == H_TOTAL - 1) begin
         h <= '0;
         v <= (32'(v) == V_TOTAL - 1) ? '0 : v + 1'b1;
      end else begin
         h <= h + 1'b1;
      end
   end

   assign active = (32'(h) < H_ACTIVE) && (32'(v) < V_ACTIVE);
   assign hs     = (32'(h) >= HS_ON) && (32'(h) < HS_ON + H_SYNC);
   assign vs     = (32'(v) >= VS_ON) && (32'(v) < VS_ON + V_SYNC);
   assign last   = (32'(h) == H_ACTIVE - 1) && (32'(v) == V_ACTIVE - 1);

   // R2: each line end advances the line counter by one
   p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(h) == H_TOTAL - 1 && 32'(v) != V_TOTAL - 1) |=> (v == $past(v) + 1'b1));
endmodule

// File: rtl/spr_store.sv
module spr_store import spr_pkg::*; #(
   parameter int NUM_SPRITES = 128,
   parameter int PIX_WORDS   = 1024,
   parameter int IDX_W       = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W+1:0]    wr_addr,
   input  logic [31:0]         wr_data,
   output logic [COLOR_W-1:0]  bg_color,
   output logic [COLOR_W-1:0]  pal   [2*NUM_PAL],
   output desc_t               desc  [NUM_SPRITES],
   output logic [ROW_BITS-1:0] bits  [PIX_WORDS]
);
   localparam int SP_W = (NUM_SPRITES > 1) ? $clog2(NUM_SPRITES) : 1;
   localparam int PA_W = $clog2(PIX_WORDS);

   logic [1:0]       region;
   logic [IDX_W-1:0] idx;
   logic [SP_W-1:0]  sp;
   logic             unused_bits;

   assign region      = wr_addr[IDX_W+1:IDX_W];
   assign idx         = wr_addr[IDX_W-1:0];
   assign sp          = SP_W'(idx >> 1);
   assign unused_bits = ^wr_data[19:18];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bg_color <= '0;
         for (int k = 0; k < 2*NUM_PAL; k++) pal[k] <= '0;
         for (int k = 0; k < NUM_SPRITES; k++) desc[k] <= '0;
      end else if (wr_en) begin
         case (region)
            RGN_BG:  if (idx == '0) bg_color <= wr_data[COLOR_W-1:0];
            RGN_PAL: if (32'(idx) < 2*NUM_PAL) pal[idx[4:0]] <= wr_data[COLOR_W-1:0];
            RGN_DESC: begin
               if ((32'(idx) >> 1) < NUM_SPRITES) begin
                  if (!idx[0]) begin
                     desc[sp].x <= wr_data[10:0];
                     desc[sp].y <= wr_data[26:16];
                  end else begin
                     desc[sp].wm1    <= wr_data[4:0];
                     desc[sp].hm1    <= wr_data[9:5];
                     desc[sp].plane  <= wr_data[11:10];
                     desc[sp].pal    <= wr_data[15:12];
                     desc[sp].en     <= wr_data[16];
                     desc[sp].opaque <= wr_data[17];
                     desc[sp].off    <= wr_data[31:20];
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && region == RGN_BITS && 32'(idx) < PIX_WORDS)
         bits[PA_W'(idx)] <= wr_data;
   end

   // R5: a background write is visible in the next cycle
   p_bg_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && region == RGN_BG && idx == '0) |=> (bg_color == $past(wr_data[COLOR_W-1:0])));
endmodule

// File: rtl/spr_pick.sv
module spr_pick import spr_pkg::*; #(
   parameter int NUM_SPRITES = 128,
   parameter int PIX_WORDS   = 1024,
   parameter int X_W         = 10,
   parameter int Y_W         = 10
) (
   input  logic [X_W-1:0]      h,
   input  logic [Y_W-1:0]      v,
   input  desc_t               desc [NUM_SPRITES],
   input  logic [ROW_BITS-1:0] bits [PIX_WORDS],
   output logic                found,
   output logic [4:0]          pal_sel
);
   localparam int PA_W = $clog2(PIX_WORDS);

   logic [NUM_SPRITES-1:0] vis;
   logic [NUM_SPRITES-1:0] pbit;

   for (genvar i = 0; i < NUM_SPRITES; i++) begin : g_spr
      logic [11:0]         dx, dy;
      logic                in_x, in_y;
      logic [PA_W-1:0]     ra;
      logic [ROW_BITS-1:0] row;

      assign dx   = 12'(h) - {1'b0, desc[i].x};
      assign dy   = 12'(v) - {1'b0, desc[i].y};
      assign in_x = (12'(h) >= {1'b0, desc[i].x}) && (dx <= 12'(desc[i].wm1));
      assign in_y = (12'(v) >= {1'b0, desc[i].y}) && (dy <= 12'(desc[i].hm1));
      assign ra   = PA_W'(desc[i].off + 12'(dy[4:0]));
      assign row  = bits[ra];
      assign pbit[i] = row[dx[4:0]];
      assign vis[i]  = desc[i].en && in_x && in_y && (pbit[i] || desc[i].opaque);
   end

   // Scan from lowest priority upward; the last match left standing wins.
   always_comb begin
      found   = 1'b0;
      pal_sel = '0;
      for (int p = NUM_PLANES - 1; p >= 0; p--) begin
         for (int i = NUM_SPRITES - 1; i >= 0; i--) begin
            if (vis[i] && desc[i].plane == 2'(p)) begin
               found   = 1'b1;
               pal_sel = {desc[i].pal, pbit[i]};
            end
         end
      end
   end
endmodule

// File: rtl/sprite_engine.sv
module sprite_engine import spr_pkg::*; #(
   parameter int NUM_SPRITES = 128,
   parameter int PIX_WORDS   = 1024,
   parameter int H_ACTIVE    = 720,
   parameter int H_FRONT     = 16,
   parameter int H_SYNC      = 62,
   parameter int H_BACK      = 60,
   parameter int V_ACTIVE    = 480,
   parameter int V_FRONT     = 9,
   parameter int V_SYNC      = 6,
   parameter int V_BACK      = 30,
   parameter int IDX_W       = idx_width(NUM_SPRITES, PIX_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W+1:0]   wr_addr,
   input  logic [31:0]        wr_data,
   output logic [COLOR_W-1:0] pix_data,
   output logic               pix_de,
   output logic               hsync,
   output logic               vsync,
   output logic               frame_irq
);
   localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
   localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
   localparam int X_W     = $clog2(H_TOTAL);
   localparam int Y_W     = $clog2(V_TOTAL);

   if (NUM_SPRITES < 1 || NUM_SPRITES > 2048) begin : g_bad_spr
      $error("NUM_SPRITES out of range");
   end
   if (PIX_WORDS < 2 || PIX_WORDS > 4096 || (PIX_WORDS & (PIX_WORDS - 1)) != 0) begin : g_bad_words
      $error("PIX_WORDS must be a power of two from 2 to 4096");
   end
   if (X_W > 11 || Y_W > 11) begin : g_bad_raster
      $error("raster exceeds 11-bit descriptor coordinates");
   end
   if (H_ACTIVE < 1 || V_ACTIVE < 1 || H_SYNC < 1 || V_SYNC < 1) begin : g_bad_timing
      $error("active area and sync widths must be non-zero");
   end
   if (IDX_W < idx_width(NUM_SPRITES, PIX_WORDS)) begin : g_bad_idx
      $error("IDX_W too narrow for the register regions");
   end

   logic [X_W-1:0]      h;
   logic [Y_W-1:0]      v;
   logic                active, hs, vs, last;
   logic [COLOR_W-1:0]  bg_color;
   logic [COLOR_W-1:0]  pal  [2*NUM_PAL];
   desc_t               desc [NUM_SPRITES];
   logic [ROW_BITS-1:0] bits [PIX_WORDS];
   logic                found;
   logic [4:0]          pal_sel;
   logic [COLOR_W-1:0]  color;

   spr_raster #(
      .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
      .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
      .X_W(X_W), .Y_W(Y_W)
   ) u_raster (
      .clk(clk), .rst_n(rst_n), .h(h), .v(v),
      .active(active), .hs(hs), .vs(vs), .last(last)
   );

   spr_store #(
      .NUM_SPRITES(NUM_SPRITES), .PIX_WORDS(PIX_WORDS), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .bg_color(bg_color), .pal(pal), .desc(desc), .bits(bits)
   );

   spr_pick #(
      .NUM_SPRITES(NUM_SPRITES), .PIX_WORDS(PIX_WORDS), .X_W(X_W), .Y_W(Y_W)
   ) u_pick (
      .h(h), .v(v), .desc(desc), .bits(bits), .found(found), .pal_sel(pal_sel)
   );

   assign color = found ? pal[pal_sel] : bg_color;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_data  <= '0;
         pix_de    <= 1'b0;
         hsync     <= 1'b0;
         vsync     <= 1'b0;
         frame_irq <= 1'b0;
      end else begin
         pix_data  <= active ? color : '0;
         pix_de    <= active;
         hsync     <= hs;
         vsync     <= vs;
         frame_irq <= last;
      end
   end

   // R4: the interrupt never lasts beyond one cycle
   p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_irq |=> !frame_irq);
   // R4: the interrupt coincides with an active pixel
   p_irq_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_irq |-> pix_de);
   // R3: syncs fall only inside blanking
   p_sync_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync || vsync) |-> !pix_de);
endmodule

// File: tb/tb_sprite_engine.sv
module tb_sprite_engine;
   localparam int HA = 16, HF = 1, HS = 2, HB = 1;
   localparam int VA = 8, VF = 1, VS = 1, VB = 0;
   localparam int HT = HA + HF + HS + HB;
   localparam int VT = VA + VF + VS + VB;
   localparam int NPIX = HA * VA;
   localparam int IDX = 6;

   localparam logic [17:0] BG = 18'h00F0F, C1 = 18'h3F000, C0 = 18'h11111, C5 = 18'h00ABC;

   logic              clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [IDX+1:0]    wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [17:0]       pix_data;
   logic              pix_de, hsync, vsync, frame_irq;

   int total = 0, bad = 0;
   logic [17:0] frm [NPIX];
   logic [17:0] expf [NPIX];
   int cyc, nde, blank_bad, hs_cnt, vs_cnt, hs_pos_bad;

   sprite_engine #(
      .NUM_SPRITES(8), .PIX_WORDS(64),
      .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
      .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
   ) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pix_data(pix_data), .pix_de(pix_de), .hsync(hsync), .vsync(vsync), .frame_irq(frame_irq)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] rgn, input int idx, input logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = {rgn, IDX'(idx)};
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_irq(input string req);
      bit seen;
      seen = 0;
      for (int n = 0; n < 3 * HT * VT && !seen; n++) begin
         @(negedge clk);
         if (frame_irq) seen = 1;
      end
      chk(req, "frame interrupt seen", 32'(seen), 32'd1);
   endtask

   // Waits for a frame end, then records the whole next frame.
   task automatic capture(input string req);
      int since;
      logic hs_prev;
      wait_irq(req);
      cyc = 0; nde = 0; blank_bad = 0; hs_cnt = 0; vs_cnt = 0; hs_pos_bad = 0;
      since = HT * 4; hs_prev = hsync;
      for (int n = 0; n < 2 * HT * VT; n++) begin
         @(negedge clk);
         cyc++;
         if (pix_de) begin
            if (nde < NPIX) frm[nde] = pix_data;
            nde++;
            since = 0;
         end else begin
            since++;
            if (pix_data != 18'd0) blank_bad++;
         end
         if (hsync) hs_cnt++;
         if (vsync) vs_cnt++;
         if (hsync && !hs_prev && since < HT && since != HF + 1) hs_pos_bad++;
         hs_prev = hsync;
         if (frame_irq) break;
      end
   endtask

   task automatic fill_exp(input logic [17:0] c);
      for (int i = 0; i < NPIX; i++) expf[i] = c;
   endtask

   task automatic set_exp(input int r, input int c, input logic [17:0] col);
      expf[r * HA + c] = col;
   endtask

   task automatic cmp_frame(input string req);
      for (int i = 0; i < NPIX; i++)
         chk(req, $sformatf("pixel row %0d col %0d", i / HA, i % HA), 32'(frm[i]), 32'(expf[i]));
      chk("R2", "blank pixels nonzero", 32'(blank_bad), 32'd0);
   endtask

   // Expected image for sprite 0 without opaque flag (rows 1..2, cols 2..5).
   task automatic exp_sprite0_clear();
      fill_exp(BG);
      set_exp(1, 2, C1); set_exp(1, 3, C1); set_exp(1, 5, C1);
      set_exp(2, 3, C1); set_exp(2, 4, C1);
   endtask

   task automatic exp_sprite0_opaque();
      exp_sprite0_clear();
      set_exp(1, 4, C0); set_exp(2, 2, C0); set_exp(2, 5, C0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "pix_de in reset", 32'(pix_de), 32'd0);
      chk("R1", "pix_data in reset", 32'(pix_data), 32'd0);
      chk("R1", "hsync in reset", 32'(hsync), 32'd0);
      chk("R1", "vsync in reset", 32'(vsync), 32'd0);
      chk("R1", "frame_irq in reset", 32'(frame_irq), 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_background();
      // R12 too: descriptors leave reset disabled, so only the background shows
      wr(2'd0, 0, 32'(BG));
      capture("R9");
      fill_exp(BG);
      cmp_frame("R9");
      chk("R2", "cycles per frame", 32'(cyc), 32'(HT * VT));
      chk("R2", "active pixels per frame", 32'(nde), 32'(NPIX));
      chk("R3", "hsync cycles per frame", 32'(hs_cnt), 32'(HS * VT));
      chk("R3", "vsync cycles per frame", 32'(vs_cnt), 32'(VS * HT));
      chk("R3", "hsync start position", 32'(hs_pos_bad), 32'd0);
      chk("R4", "pix_de with frame_irq", 32'(pix_de), 32'd1);
   endtask

   task automatic t_sprite_basic();
      wr(2'd1, 6, 32'(C0));               // R5 palette 3 entry 0
      wr(2'd1, 7, 32'(C1));               // palette 3 entry 1
      wr(2'd3, 10, 32'b1011);             // R7 row 0: cols 0,1,3
      wr(2'd3, 11, 32'b0110);             // row 1: cols 1,2
      wr(2'd2, 0, 32'h0001_0002);         // R6 x=2 y=1
      wr(2'd2, 1, 32'h00A1_3423);         // w=4 h=2 plane1 pal3 en off=10
      capture("R7");
      exp_sprite0_clear();
      cmp_frame("R7 R8 R6");
   endtask

   task automatic t_opaque();
      wr(2'd2, 1, 32'h00A3_3423);         // R8 opaque set
      capture("R8");
      exp_sprite0_opaque();
      cmp_frame("R8 opaque");
   endtask

   task automatic t_plane_priority();
      wr(2'd1, 9, 32'(C5));               // palette 4 entry 1
      wr(2'd3, 12, 32'd1);
      wr(2'd2, 10, 32'h0001_0003);        // sprite 5 at x=3 y=1
      wr(2'd2, 11, 32'h00C1_4000);        // 1x1 plane0 pal4 en off=12
      capture("R10");
      exp_sprite0_opaque();
      set_exp(1, 3, C5);
      cmp_frame("R10 lower plane wins");
   endtask

   task automatic t_index_priority();
      wr(2'd2, 11, 32'h00C1_4400);        // sprite 5 moved to plane 1
      capture("R11");
      exp_sprite0_opaque();
      cmp_frame("R11 lower index wins");
   endtask

   task automatic t_fallthrough();
      wr(2'd2, 1, 32'h00A1_3423);         // sprite 0 opaque cleared
      wr(2'd2, 11, 32'h00C1_4000);        // sprite 5 back on plane 0
      wr(2'd3, 12, 32'd0);                // its only pixel transparent
      capture("R8");
      exp_sprite0_clear();
      cmp_frame("R8 transparent falls through");
   endtask

   task automatic t_disable();
      wr(2'd2, 1, 32'h00A2_3423);         // R12 opaque but not enabled
      wr(2'd2, 11, 32'h00C2_4000);
      capture("R12");
      fill_exp(BG);
      cmp_frame("R12 disabled sprites");
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      t_reset();
      t_background();
      t_sprite_basic();
      t_opaque();
      t_plane_priority();
      t_index_priority();
      t_fallthrough();
      t_disable();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      finish_run();
   end
endmodule